// File: doc/BRIEF.md
# BCH t=8 Error-Location Correction Mapper

This block sits after the error locator of a BCH decoder that corrects up to eight bit errors. The protected unit is a 512-byte sector followed by a 13-byte parity code and one spare byte. The block first looks at the parity computed during the read and at the parity stored in the spare area. Either one can show that no correction is needed: a sector with no errors, or a page that has never been programmed. If neither does, it turns each bit location from the locator into a correction command. A command either flips a bit in the data buffer, flips a bit in the stored parity bytes, or is rejected as out of range.

A sector starts with a one-cycle `start`. On that cycle the block reads the two parity vectors, the locator's failure flag, the error count and the list of locations. Corrections then leave one per transfer on a valid/ready stream. A one-cycle `done` closes the sector and carries the number of corrections issued and a failure flag. The block also presents the computed parity with the 13 code bytes in reverse order, which is the byte order the locator expects.

Top module: `bch8_corrmap`

## Requirements
- R1: After reset, `corr_valid`, `done`, `done_fail` and `done_count` are all 0.
- R2: `lane_code` is combinational from `calc_code`. Byte i of `lane_code` (bits 8i+7..8i) equals `calc_code` byte 12−i for i in 0..12, and byte 13 is 0x00.
- R3: If bytes 0..12 of `calc_code` are all zero on the `start` cycle, the next cycle carries `done` with `done_count`=0 and `done_fail`=0, and no correction is issued. This holds whatever the values of byte 13, `stored_code` and `uncorrectable`.
- R4: If R3 does not apply and all 14 bytes of `stored_code` are 0xFF on the `start` cycle, the sector is treated as erased. The next cycle carries `done` with `done_count`=0 and `done_fail`=0, and no correction is issued, even when `uncorrectable` is 1.
- R5: If neither R3 nor R4 applies and `uncorrectable` is 1, the next cycle carries `done` with `done_fail`=1 and `done_count`=0, and no correction is issued.
- R6: For a location L, let b = floor(L/8) and mask = 1 << (L mod 8).
  - If b ≤ 12, the correction has `corr_oob`=1 and `corr_offset`=12−b.
  - If 13 ≤ b ≤ 524, the correction has `corr_oob`=0 and `corr_offset`=524−b.
- R7: A location with b > 524 issues no correction. It sets `done_fail`=1 for the sector, and `done_count` still counts the corrections that were issued.
- R8: Locations are taken in list order, entry 0 first, with entry j at `loc_list` bits 13j+12..13j. Entries at or beyond the error count have no effect.
- R9: While `corr_valid` is 1 and `corr_ready` is 0, the command stays valid and its area, offset and mask stay unchanged. Each cycle with both high transfers one command.
- R10: After the last entry, `done` is high for exactly one cycle and `done_count` equals the number of commands transferred. `done_count` and `done_fail` then hold until the next `done`.
- R11: An `err_count` above 8 is processed as 8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a sector; the inputs below are sampled on this cycle |
| calc_code | input | 112 | Parity computed during the read, byte k at bits 8k+7..8k |
| stored_code | input | 112 | Parity read back from the spare area, same byte layout |
| err_count | input | 4 | Number of valid locations in the list |
| uncorrectable | input | 1 | The locator could not solve the sector |
| loc_list | input | 104 | Eight 13-bit bit locations, entry j at bits 13j+12..13j |
| lane_code | output | 112 | Computed parity with the code bytes reversed, for the locator |
| corr_valid | output | 1 | A correction command is offered |
| corr_ready | input | 1 | The consumer accepts the command |
| corr_oob | output | 1 | 1: the command targets the parity bytes; 0: the data buffer |
| corr_offset | output | 9 | Byte offset within the target area |
| corr_mask | output | 8 | Bit to flip, one-hot |
| done | output | 1 | Sector finished (one-cycle pulse) |
| done_fail | output | 1 | The sector was uncorrectable or held an invalid location |
| done_count | output | 4 | Corrections issued for the sector |

## Verification
The assertions assume that `start` is raised only while the block is idle, that is, not between a `start` and its `done`. They also assume that the parity vectors, the flag, the count and the list are valid on the `start` cycle. The stimulus keeps to this: the bench raises `start` only after it has seen the previous `done`, and it sets every input on the same falling edge on which it raises `start`. The stream assertions also assume that a stalled command is never withdrawn by the consumer. The bench drives `corr_ready` only from a fixed pattern of cycles, never from the command's contents.

// File: rtl/bch8_map_pkg.sv
package bch8_map_pkg;
  localparam int DATA_BYTES = 512;
  localparam int CODE_BYTES = 13;
  localparam int SLOT_BYTES = 14;
  localparam int MAX_ERR    = 8;
  localparam int LOC_W      = 13;
  localparam int SPAN       = DATA_BYTES + CODE_BYTES;
  localparam int OFF_W      = $clog2(DATA_BYTES);
  localparam int CNT_W      = $clog2(MAX_ERR + 1);

  typedef enum logic {ST_IDLE, ST_RUN} seq_st_e;

  typedef struct packed {
    logic             bad;
    logic             oob;
    logic [OFF_W-1:0] off;
    logic [7:0]       mask;
  } fix_t;
endpackage

// File: rtl/bch8_screen.sv
module bch8_screen
  import bch8_map_pkg::*;
(
  input  logic [SLOT_BYTES*8-1:0] calc_code,
  input  logic [SLOT_BYTES*8-1:0] stored_code,
  output logic                    clean,
  output logic                    erased
);
  logic [CODE_BYTES-1:0] calc_nz;
  logic [SLOT_BYTES-1:0] st_ff;

  // the spare parity byte is left out of the zero test
  for (genvar g = 0; g < CODE_BYTES; g++) begin : g_nz
    assign calc_nz[g] = |calc_code[8*g +: 8];
  end
  for (genvar g = 0; g < SLOT_BYTES; g++) begin : g_ff
    assign st_ff[g] = &stored_code[8*g +: 8];
  end

  assign clean  = ~|calc_nz;
  assign erased = &st_ff;
endmodule

// File: rtl/bch8_locxlat.sv
module bch8_locxlat
  import bch8_map_pkg::*;
(
  input  logic [LOC_W-1:0] loc,
  output fix_t             fix
);
  logic [LOC_W-1:0] byte_idx;
  logic [LOC_W-1:0] pos;
  logic             over;

  always_comb begin
    byte_idx = loc >> 3;
    over     = byte_idx > LOC_W'(SPAN - 1);
    // positions are counted back from the last code byte
    pos      = LOC_W'(SPAN - 1) - byte_idx;
    fix.bad  = over;
    fix.oob  = !over && (pos >= LOC_W'(DATA_BYTES));
    fix.off  = fix.oob ? OFF_W'(pos - LOC_W'(DATA_BYTES)) : OFF_W'(pos);
    fix.mask = 8'd1 << loc[2:0];
  end
endmodule

// File: rtl/bch8_seq.sv
module bch8_seq
  import bch8_map_pkg::*;
(
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     start,
  input  logic                     clean,
  input  logic                     erased,
  input  logic                     uncorr,
  input  logic [CNT_W-1:0]         err_count,
  input  logic [MAX_ERR*LOC_W-1:0] loc_list,
  input  logic                     loc_bad,
  input  logic                     corr_ready,
  output logic [LOC_W-1:0]         cur_loc,
  output logic                     corr_valid,
  output logic                     done,
  output logic                     done_fail,
  output logic [CNT_W-1:0]         done_count
);
  localparam int IDX_W = (MAX_ERR > 1) ? $clog2(MAX_ERR) : 1;

  seq_st_e                         st_q, st_d;
  logic [CNT_W-1:0]                idx_q, idx_d, lim_q, lim_d;
  logic [CNT_W-1:0]                ncorr_q, ncorr_d, cnt_q, cnt_d;
  logic                            bad_q, bad_d, fail_q, fail_d, done_q, done_d;
  logic [MAX_ERR-1:0][LOC_W-1:0]   locs_q;
  logic                            cap_en, more;
  logic [CNT_W-1:0]                lim_cap;

  assign cap_en     = (st_q == ST_IDLE) && start;
  assign lim_cap    = (err_count > CNT_W'(MAX_ERR)) ? CNT_W'(MAX_ERR) : err_count;
  assign more       = idx_q < lim_q;
  assign cur_loc    = locs_q[idx_q[IDX_W-1:0]];
  assign corr_valid = (st_q == ST_RUN) && more && !loc_bad;
  assign done       = done_q;
  assign done_fail  = fail_q;
  assign done_count = cnt_q;

  always_comb begin
    st_d    = st_q;
    idx_d   = idx_q;
    lim_d   = lim_q;
    ncorr_d = ncorr_q;
    bad_d   = bad_q;
    fail_d  = fail_q;
    cnt_d   = cnt_q;
    done_d  = 1'b0;
    case (st_q)
      ST_IDLE: begin
        if (start) begin
          if (clean || erased) begin
            done_d = 1'b1;
            fail_d = 1'b0;
            cnt_d  = '0;
          end else if (uncorr) begin
            done_d = 1'b1;
            fail_d = 1'b1;
            cnt_d  = '0;
          end else begin
            st_d    = ST_RUN;
            idx_d   = '0;
            ncorr_d = '0;
            bad_d   = 1'b0;
            lim_d   = lim_cap;
          end
        end
      end
      ST_RUN: begin
        if (!more) begin
          st_d   = ST_IDLE;
          done_d = 1'b1;
          fail_d = bad_q;
          cnt_d  = ncorr_q;
        end else if (loc_bad) begin
          bad_d = 1'b1;
          idx_d = idx_q + 1'b1;
        end else if (corr_ready) begin
          ncorr_d = ncorr_q + 1'b1;
          idx_d   = idx_q + 1'b1;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      idx_q   <= '0;
      lim_q   <= '0;
      ncorr_q <= '0;
      bad_q   <= 1'b0;
      fail_q  <= 1'b0;
      cnt_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      st_q    <= st_d;
      idx_q   <= idx_d;
      lim_q   <= lim_d;
      ncorr_q <= ncorr_d;
      bad_q   <= bad_d;
      fail_q  <= fail_d;
      cnt_q   <= cnt_d;
      done_q  <= done_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      locs_q <= '0;
    else if (cap_en) locs_q <= loc_list;
  end

  // R9: a stalled command keeps its location
  p_stall_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    corr_valid && !corr_ready |=> corr_valid && $stable(cur_loc));
  // R10: done is a single-cycle pulse and never overlaps a command
  p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_done_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !corr_valid);
  // R11: the count never exceeds the list depth
  p_count_bound_r11: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> done_count <= CNT_W'(MAX_ERR));
endmodule

// File: rtl/bch8_corrmap.sv
module bch8_corrmap
  import bch8_map_pkg::*;
(
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     start,
  input  logic [SLOT_BYTES*8-1:0]  calc_code,
  input  logic [SLOT_BYTES*8-1:0]  stored_code,
  input  logic [CNT_W-1:0]         err_count,
  input  logic                     uncorrectable,
  input  logic [MAX_ERR*LOC_W-1:0] loc_list,
  output logic [SLOT_BYTES*8-1:0]  lane_code,
  output logic                     corr_valid,
  input  logic                     corr_ready,
  output logic                     corr_oob,
  output logic [OFF_W-1:0]         corr_offset,
  output logic [7:0]               corr_mask,
  output logic                     done,
  output logic                     done_fail,
  output logic [CNT_W-1:0]         done_count
);
  logic             clean, erased;
  logic [LOC_W-1:0] cur_loc;
  fix_t             fix;

  for (genvar g = 0; g < SLOT_BYTES; g++) begin : g_lane
    if (g < CODE_BYTES) begin : g_rev
      assign lane_code[8*g +: 8] = calc_code[8*(CODE_BYTES-1-g) +: 8];
    end else begin : g_pad
      assign lane_code[8*g +: 8] = 8'h00;
    end
  end

  bch8_screen u_screen (
    .calc_code   (calc_code),
    .stored_code (stored_code),
    .clean       (clean),
    .erased      (erased)
  );

  bch8_locxlat u_xlat (
    .loc (cur_loc),
    .fix (fix)
  );

  bch8_seq u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .clean      (clean),
    .erased     (erased),
    .uncorr     (uncorrectable),
    .err_count  (err_count),
    .loc_list   (loc_list),
    .loc_bad    (fix.bad),
    .corr_ready (corr_ready),
    .cur_loc    (cur_loc),
    .corr_valid (corr_valid),
    .done       (done),
    .done_fail  (done_fail),
    .done_count (done_count)
  );

  assign corr_oob    = fix.oob;
  assign corr_offset = fix.off;
  assign corr_mask   = fix.mask;

  // R6: a parity-area command stays inside the code bytes
  p_oob_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
    corr_valid && corr_oob |-> corr_offset < OFF_W'(CODE_BYTES));
  // R6: exactly one bit is flipped per command
  p_mask_onehot_r6: assert property (@(posedge clk) disable iff (!rst_n)
    corr_valid |-> $countones(corr_mask) == 1);
  // R9: a stalled command keeps its target
  p_fields_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    corr_valid && !corr_ready |=> $stable(corr_oob) && $stable(corr_offset) && $stable(corr_mask));
endmodule

// File: tb/bch8_corrmap_tb.sv
module bch8_corrmap_tb;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start = 1'b0;
  logic [111:0] calc_code = '0;
  logic [111:0] stored_code = '0;
  logic [3:0]   err_count = '0;
  logic         uncorrectable = 1'b0;
  logic [103:0] loc_list = '0;
  logic [111:0] lane_code;
  logic         corr_valid;
  logic         corr_ready = 1'b0;
  logic         corr_oob;
  logic [8:0]   corr_offset;
  logic [7:0]   corr_mask;
  logic         done, done_fail;
  logic [3:0]   done_count;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int rdy_mode = 0;
  bit finished = 0;
  int locs [8];

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  bch8_corrmap u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .calc_code(calc_code),
    .stored_code(stored_code), .err_count(err_count), .uncorrectable(uncorrectable),
    .loc_list(loc_list), .lane_code(lane_code), .corr_valid(corr_valid),
    .corr_ready(corr_ready), .corr_oob(corr_oob), .corr_offset(corr_offset),
    .corr_mask(corr_mask), .done(done), .done_fail(done_fail), .done_count(done_count)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h", tag, act, exp);
    end
  endtask

  // R6/R7 expectation: returns 0 for invalid
  function automatic bit expect_fix(input int loc, output bit oob, output int off, output int mask);
    int pos;
    pos  = 524 - loc / 8;
    mask = 1 << (loc % 8);
    oob  = 1'b0;
    off  = 0;
    if (pos < 0) return 1'b0;
    if (pos < 512) off = pos;
    else begin oob = 1'b1; off = pos - 512; end
    return 1'b1;
  endfunction

  task automatic run_sector(input logic [111:0] cc, input logic [111:0] sc,
                            input bit unc, input int cnt, input string tag);
    bit    e_oob [8];
    int    e_off [8];
    int    e_mask[8];
    int    n_exp = 0;
    bit    e_fail = 0;
    int    lim;
    int    k = 0;
    bit    stall = 0;
    bit    s_oob = 0;
    int    s_off = 0, s_mask = 0;
    bit    seen_done = 0;
    bit    clean_c, erased_c;
    clean_c  = (cc[103:0] == '0);
    erased_c = (sc == {112{1'b1}});
    lim = (cnt > 8) ? 8 : cnt;
    if (clean_c || erased_c) e_fail = 0;
    else if (unc) e_fail = 1;
    else begin
      for (int j = 0; j < lim; j++) begin
        bit o; int f, m;
        if (expect_fix(locs[j], o, f, m)) begin
          e_oob[n_exp] = o; e_off[n_exp] = f; e_mask[n_exp] = m; n_exp++;
        end else e_fail = 1;
      end
    end
    @(negedge clk);
    calc_code = cc; stored_code = sc; uncorrectable = unc; err_count = 4'(cnt);
    for (int j = 0; j < 8; j++) loc_list[13*j +: 13] = 13'(locs[j]);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int t = 0; t < 100; t++) begin
      corr_ready = (rdy_mode == 0) ? 1'b1 : ((cyc % 3) != 1);
      #1;
      if (stall) begin
        chk({tag, " R9 held valid"}, corr_valid, 1);
        chk({tag, " R9 held offset"}, corr_offset, s_off);
        chk({tag, " R9 held mask"}, corr_mask, s_mask);
        chk({tag, " R9 held area"}, corr_oob, s_oob);
        stall = 0;
      end
      if (done) begin seen_done = 1; break; end
      if (corr_valid && !corr_ready) begin
        stall = 1; s_oob = corr_oob; s_off = corr_offset; s_mask = corr_mask;
      end
      if (corr_valid && corr_ready) begin
        if (k < n_exp) begin
          chk({tag, " R6/R8 area"}, corr_oob, e_oob[k]);
          chk({tag, " R6/R8 offset"}, corr_offset, e_off[k]);
          chk({tag, " R6 mask"}, corr_mask, e_mask[k]);
        end else chk({tag, " R8 extra command"}, 1, 0);
        k++;
      end
      @(negedge clk);
    end
    chk({tag, " R10 done seen"}, seen_done, 1);
    chk({tag, " R10 commands"}, k, n_exp);
    chk({tag, " R10 count"}, done_count, n_exp);
    chk({tag, " R5/R7 fail"}, done_fail, e_fail);
    @(negedge clk);
    chk({tag, " R10 pulse width"}, done, 0);
    chk({tag, " R10 count hold"}, done_count, n_exp);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [111:0] cc;
    logic [111:0] ffs;
    ffs = {112{1'b1}};
    repeat (3) @(negedge clk);
    chk("R1 valid", corr_valid, 0);
    chk("R1 done", done, 0);
    chk("R1 fail", done_fail, 0);
    chk("R1 count", done_count, 0);
    rst_n = 1'b1;

    // R2 lane reversal
    for (int i = 0; i < 14; i++) cc[8*i +: 8] = 8'(i * 17 + 3);
    calc_code = cc;
    #1;
    for (int i = 0; i < 13; i++) chk("R2 lane byte", lane_code[8*i +: 8], cc[8*(12-i) +: 8]);
    chk("R2 spare lane", lane_code[111:104], 0);

    for (int j = 0; j < 8; j++) locs[j] = 100 + j * 40;
    // R3: zero code, reserved byte set, flag raised
    run_sector({8'h5A, 104'h0}, 112'h0, 1'b1, 8, "R3 clean");
    // R4: erased page beats the flag
    run_sector(112'h1, ffs, 1'b1, 8, "R4 erased");
    // R4 negative: one stored byte not erased
    run_sector(112'h1, {8'hFE, 104'hFF_FFFF_FFFF_FFFF_FFFF_FFFF_FFFF}, 1'b0, 8, "R4 not erased");
    // R5 uncorrectable
    run_sector(112'h1, 112'h0, 1'b1, 8, "R5 uncorr");

    // R8/R11: count sweep, invalid entries in unused slots
    rdy_mode = 1;
    for (int c = 0; c < 16; c++) begin
      for (int j = 0; j < 8; j++) locs[j] = (j < c) ? (j * 523 + 7) % 4200 : 8000;
      run_sector(112'h1, 112'h0, 1'b0, c, "R8/R11 count sweep");
    end

    // R6/R7: every location value, eight per sector in scrambled order
    for (int base = 0; base < 8192; base += 8) begin
      rdy_mode = (base / 8) % 2;
      for (int j = 0; j < 8; j++) locs[j] = (base + j * 1031) % 8192;
      run_sector(112'h2, 112'h0, 1'b0, 8, "R6/R7 sweep");
    end

    // R6/R7 boundaries
    rdy_mode = 1;
    locs = '{0, 7, 103, 104, 4199, 4200, 8191, 4192};
    run_sector(112'h3, 112'h0, 1'b0, 8, "R6/R7 edges");

    finished = 1;
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule